// File: doc/BRIEF.md
# Signed Halfword Multiply Execution Unit

This unit handles one instruction class: the signed 16x16 multiply. Each operand comes from either the upper or the lower half of a 32-bit register. Each cycle it accepts one 32-bit instruction word, the two source register values already read from the register file, and the four status flags. From the instruction word it works out three things: whether the word belongs to this class, whether its condition code lets it execute, and which half of each source to use. It sign-extends the two chosen halves, multiplies them, and returns the 32-bit product with a destination index and a write strobe.

The unit has two pipeline stages. In the first stage it decodes the word and selects the halves. In the second stage it multiplies and registers the outputs. A valid bit travels through the pipeline with the data, so the unit accepts a new word on every cycle. The unit never changes the status flags, and no overflow can occur.

Top module: `hmul_exec`

## Requirements
- R1: The first 16-bit operand is `src_a[31:16]` when instruction bit 5 is 1, and `src_a[15:0]` otherwise. The second operand is `src_b[31:16]` when bit 6 is 1, and `src_b[15:0]` otherwise. The unselected half of each source has no effect on the result.
- R2: Both operands are two's-complement values. `wr_data` is the low 32 bits of their signed product. For example, -32768 x -32768 gives 0x40000000 and -32768 x 32767 gives 0xC0008000.
- R3: A word belongs to this class only if all of these hold: bits [27:20] = 0x16, bits [15:12] = 0, bit 7 = 1 and bit 4 = 0. `wr_idx` is taken from bits [19:16].
- R4: A word whose condition field (bits [31:28]) is 1111 is treated as not belonging to this class.
- R5: The condition field is evaluated against `flags_nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) with the usual 16-entry code. Examples: 0000 requires Z, 0001 requires !Z, 1000 requires C&!Z, 1010 requires N==V, 1011 requires N!=V, and 1110 always passes.
- R6: `wr_en` is 1 only for a valid, decoded word whose condition passes. While `wr_en` is 0, `wr_data` is 0.
- R7: `not_decoded` is 1 for exactly one output cycle for each valid word that does not belong to this class. It is never 1 at the same time as `wr_en`.
- R8: A word presented with `in_valid` before clock edge k appears on the outputs after edge k+2. `out_valid` follows `in_valid` with that delay, and a new word can be accepted on every cycle.
- R9: A synchronous active-high `rst` clears both pipeline valid bits. While `rst` is held, and at every edge where it is sampled high, nothing in flight reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| flags_nzcv | input | 4 | Status flags N, Z, C, V (MSB first) |
| out_valid | output | 1 | A result slot is present |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Product to write |
| not_decoded | output | 1 | The valid word was not a member of this class |

## Verification
The bench checks all four half-select combinations using sources whose unused halves hold non-zero values. A wrong select would pick up the other half, and a wrong sign-extension would produce a huge positive product instead of a small negative one. The most negative operand squared must give 0x40000000 and must not be treated as overflow, and -32768 x 32767 checks sign handling at the opposite extreme. It exercises the condition codes on both their passing and failing flag sets. A broken condition path would write when it should skip, or skip when it should write. The bench also sends words that miss each decode field in turn, including the all-ones condition code: a loose decoder would write instead of raising `not_decoded`. Finally, a reset with a word in flight must drop that word, otherwise a stale write would appear afterwards.

// File: rtl/hmul_pkg.sv
package hmul_pkg;
  localparam int XLEN   = 32;
  localparam int HALF   = XLEN / 2;
  localparam int RIDX_W = 4;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Picks one halfword out of a register value.
  function automatic logic [HALF-1:0] take_half(input logic [XLEN-1:0] r, input logic upper);
    return upper ? r[XLEN-1:HALF] : r[HALF-1:0];
  endfunction

  // Sign-extends two halfwords and keeps the low word of the product.
  function automatic logic [XLEN-1:0] signed_prod(input logic [HALF-1:0] a, input logic [HALF-1:0] b);
    logic signed [XLEN-1:0] ea;
    logic signed [XLEN-1:0] eb;
    ea = {{HALF{a[HALF-1]}}, a};
    eb = {{HALF{b[HALF-1]}}, b};
    return XLEN'(ea * eb);
  endfunction

  // Standard 4-bit condition code over the status flags.
  function automatic logic code_passes(input logic [CODE_W-1:0] code, input nzcv_t f);
    logic base;
    case (code[CODE_W-1:1])
      3'd0:    base = f.z;
      3'd1:    base = f.c;
      3'd2:    base = f.n;
      3'd3:    base = f.v;
      3'd4:    base = f.c & ~f.z;
      3'd5:    base = (f.n == f.v);
      3'd6:    base = ~f.z & (f.n == f.v);
      default: base = 1'b1;
    endcase
    return (code == 4'b1110) ? 1'b1 : (base ^ code[0]);
  endfunction
endpackage

// File: rtl/hmul_decode.sv
module hmul_decode
  import hmul_pkg::*;
(
  input  logic [XLEN-1:0]   word,
  output logic              is_member,
  output logic [CODE_W-1:0] cond_code,
  output logic [RIDX_W-1:0] dst_idx,
  output logic              a_upper,
  output logic              b_upper
);
  localparam logic [7:0] MAJOR = 8'h16;

  logic fields_ok;
  logic never_code;

  assign cond_code  = word[31:28];
  assign never_code = (cond_code == 4'b1111);
  assign fields_ok  = (word[27:20] == MAJOR) && (word[15:12] == 4'h0)
                    && word[7] && !word[4];
  assign is_member  = fields_ok && !never_code;
  assign dst_idx    = word[19:16];
  assign a_upper    = word[5];
  assign b_upper    = word[6];

  // R4: the all-ones condition never decodes
  always_comb begin
    if (never_code) a_r4_never_member: assert (!is_member);
  end
endmodule

// File: rtl/hmul_cond.sv
module hmul_cond
  import hmul_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [3:0]        flags,
  output logic              pass
);
  nzcv_t f;
  assign f    = nzcv_t'(flags);
  assign pass = code_passes(code, f);
endmodule

// File: rtl/hmul_mult.sv
module hmul_mult
  import hmul_pkg::*;
(
  input  logic [HALF-1:0] op_a,
  input  logic [HALF-1:0] op_b,
  output logic [XLEN-1:0] prod
);
  assign prod = signed_prod(op_a, op_b);
endmodule

// File: rtl/hmul_exec.sv
module hmul_exec
  import hmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [3:0]        flags_nzcv,
  output logic              out_valid,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              not_decoded
);
  // decode / select stage
  logic              dec_member;
  logic [CODE_W-1:0] dec_code;
  logic [RIDX_W-1:0] dec_dst;
  logic              dec_a_up;
  logic              dec_b_up;
  logic              cond_ok;

  hmul_decode u_dec (
    .word      (instr),
    .is_member (dec_member),
    .cond_code (dec_code),
    .dst_idx   (dec_dst),
    .a_upper   (dec_a_up),
    .b_upper   (dec_b_up)
  );

  hmul_cond u_cond (
    .code  (dec_code),
    .flags (flags_nzcv),
    .pass  (cond_ok)
  );

  logic              s1_valid;
  logic              s1_go;
  logic              s1_miss;
  logic [RIDX_W-1:0] s1_dst;
  logic [HALF-1:0]   s1_opa;
  logic [HALF-1:0]   s1_opb;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_go   <= dec_member & cond_ok;
    s1_miss <= ~dec_member;
    s1_dst  <= dec_dst;
    s1_opa  <= take_half(src_a, dec_a_up);
    s1_opb  <= take_half(src_b, dec_b_up);
  end

  // multiply / output stage
  logic [XLEN-1:0] mul_out;
  logic            fire;
  logic            reject;

  hmul_mult u_mul (
    .op_a (s1_opa),
    .op_b (s1_opb),
    .prod (mul_out)
  );

  assign fire   = s1_valid & s1_go;
  assign reject = s1_valid & s1_miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      wr_en       <= 1'b0;
      not_decoded <= 1'b0;
      wr_data     <= '0;
    end else begin
      out_valid   <= s1_valid;
      wr_en       <= fire;
      not_decoded <= reject;
      wr_data     <= fire ? mul_out : '0;
    end
    wr_idx <= s1_dst;
  end

  // R8: output valid trails the first stage by one edge
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  a_r8_bubble_follows: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);
  // R6: writes only inside a valid slot, data cleared otherwise
  a_r6_write_in_slot: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);
  a_r6_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_data == '0));
  // R7: a rejected word never writes
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && not_decoded));
  a_r7_in_slot: assert property (@(posedge clk) disable iff (rst)
    not_decoded |-> out_valid);
  // R2: product of two halfwords always fits in a signed word
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data == 32'h4000_0000 || wr_data[31] == wr_data[30]));
  // R9: reset empties the pipeline
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !s1_valid && !wr_en));
endmodule

// File: tb/sim_hmul_exec.sv
`timescale 1ns/100ps
module sim_hmul_exec;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, src_a, src_b;
  logic [3:0]  flags_nzcv;
  logic        out_valid, wr_en, not_decoded;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hmul_exec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .flags_nzcv(flags_nzcv),
    .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .not_decoded(not_decoded)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fl;
    logic        we;
    logic        nd;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{32'hE163_0080, 32'h0000_0003, 32'h0000_0005, 4'h0, 1'b1, 1'b0, 32'h0000_000F}, // R1 bottom/bottom
    '{32'hE165_00A0, 32'hFFFE_0000, 32'h0000_0007, 4'h0, 1'b1, 1'b0, 32'hFFFF_FFF2}, // R1 top/bottom
    '{32'hE16A_00C0, 32'h0000_0004, 32'h0009_1234, 4'h0, 1'b1, 1'b0, 32'h0000_0024}, // R1 bottom/top
    '{32'hE16F_00E0, 32'h8000_1111, 32'h8000_2222, 4'h0, 1'b1, 1'b0, 32'h4000_0000}, // R2 min*min
    '{32'hE161_0080, 32'h0000_8000, 32'h0000_7FFF, 4'h0, 1'b1, 1'b0, 32'hC000_8000}, // R2 min*max
    '{32'hE162_0080, 32'hABCD_0003, 32'h1234_0005, 4'h0, 1'b1, 1'b0, 32'h0000_000F}, // R1 ignored half
    '{32'h0163_0080, 32'h0000_0002, 32'h0000_0003, 4'h0, 1'b0, 1'b0, 32'h0000_0000}, // R5 EQ, Z=0
    '{32'h0164_0080, 32'h0000_0002, 32'h0000_0003, 4'h4, 1'b1, 1'b0, 32'h0000_0006}, // R5 EQ, Z=1
    '{32'hA165_0080, 32'h0000_FFFF, 32'h0000_FFFF, 4'h9, 1'b1, 1'b0, 32'h0000_0001}, // R5 GE N=V=1
    '{32'hB166_0080, 32'h0000_FFFF, 32'h0000_0002, 4'h8, 1'b1, 1'b0, 32'hFFFF_FFFE}, // R5 LT N!=V
    '{32'h8167_0080, 32'h0000_0002, 32'h0000_0003, 4'h6, 1'b0, 1'b0, 32'h0000_0000}, // R5 HI fails Z=1
    '{32'hF168_0080, 32'h0000_0001, 32'h0000_0001, 4'h0, 1'b0, 1'b1, 32'h0000_0000}, // R4 code 1111
    '{32'hE169_0090, 32'h0000_0001, 32'h0000_0001, 4'h0, 1'b0, 1'b1, 32'h0000_0000}, // R3 bit4 set
    '{32'hE16A_1080, 32'h0000_0001, 32'h0000_0001, 4'h0, 1'b0, 1'b1, 32'h0000_0000}, // R3 bits15:12
    '{32'hE170_0080, 32'h0000_0001, 32'h0000_0001, 4'h0, 1'b0, 1'b1, 32'h0000_0000}, // R3 major field
    '{32'h116B_0080, 32'h0000_0007, 32'h0000_FFFF, 4'h0, 1'b1, 1'b0, 32'hFFFF_FFF9}  // R5 NE, Z=0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input vec_t t);
    in_valid   = v;
    instr      = t.ins;
    src_a      = t.a;
    src_b      = t.b;
    flags_nzcv = t.fl;
  endtask

  task automatic check_slot(input vec_t t);
    chk("R8 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R6 wr_en", {31'd0, wr_en}, {31'd0, t.we});
    chk("R7 not_decoded", {31'd0, not_decoded}, {31'd0, t.nd});
    chk("R2 wr_data", wr_data, t.d);
    if (t.we) chk("R3 wr_idx", {28'd0, wr_idx}, {28'd0, t.ins[19:16]});
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, TBL[0]);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R9 wr_en in reset", {31'd0, wr_en}, 32'd0);
    chk("R9 not_decoded in reset", {31'd0, not_decoded}, 32'd0);
    rst = 1'b0;

    // R8: stream the table back to back, result two edges later
    for (int k = 0; k < NV + 2; k++) begin
      if (k >= 2) check_slot(TBL[k-2]);
      if (k < NV) drive(1'b1, TBL[k]);
      else        drive(1'b0, TBL[0]);
      @(negedge clk);
    end
    chk("R8 bubble out_valid", {31'd0, out_valid}, 32'd0);

    // R6: matching word with in_valid low does not write
    drive(1'b0, TBL[0]);
    repeat (2) @(negedge clk);
    chk("R6 no write without valid", {31'd0, wr_en}, 32'd0);
    chk("R6 no data without valid", wr_data, 32'd0);

    // R9: reset while a word is in flight drops it
    drive(1'b1, TBL[3]);
    @(negedge clk);
    drive(1'b0, TBL[3]);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 flight dropped out_valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R9 flight dropped wr_en", {31'd0, wr_en}, 32'd0);
    chk("R9 flight dropped out_valid late", {31'd0, out_valid}, 32'd0);

    // R1: single isolated top/top word with noisy other halves
    drive(1'b1, '{32'hE164_00E0, 32'hFFFF_7FFF, 32'h0003_8001, 4'h0, 1'b1, 1'b0, 32'hFFFF_FFFD});
    @(negedge clk);
    drive(1'b0, TBL[0]);
    @(negedge clk);
    chk("R1 top/top data", wr_data, 32'hFFFF_FFFD);
    chk("R1 top/top write", {31'd0, wr_en}, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule